// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a clocked sequencer that turns single-word requests into correctly timed strobe sequences for an external asynchronous static RAM. The RAM holds 128K words of 16 bits. A client presents a word address, write data, a read/write flag and a two-bit lane mask while holding a valid strobe. The controller accepts the request only when it is ready. It then drives the memory's active-low chip enable, output enable, write enable and the two active-low byte-lane controls. It finishes with a one-cycle done pulse, which for a read carries the captured word.

All memory timing minimums are parameters in nanoseconds, together with the clock period. At elaboration each minimum is rounded up to a whole number of clock cycles, and each resulting count is at least one. The pulse, sample and release points therefore track any clock frequency without RTL edits.

The data bus is brought out as separate in, out and drive-enable signals, so a pad ring or a bench can form the bidirectional pin. Between transactions the controller holds the RAM deselected. After every read it waits out the RAM's output float time before it drives the bus again.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever no transaction is in flight, `req_ready` is 1, `done` is 0, `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are all 1, and `mem_dq_oe` is 0.
- R2: A read with a non-zero mask holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for at least ceil(55 ns / clock) cycles (6 at 10 ns) before `rdata` is captured. `done` is then high for exactly one cycle, with `rdata` valid in that cycle.
- R3: Mask bit 0 selects the lower lane (data bits 7:0, `mem_lb_n` low) and mask bit 1 selects the upper lane (bits 15:8, `mem_ub_n` low). On a read, a lane whose mask bit is 0 returns zero in `rdata`, whatever is on `mem_dq_in`.
- R4: `mem_we_n` is low only while `mem_ce_n` is low and at least one of `mem_lb_n`/`mem_ub_n` is low. Each write-enable pulse lasts at least ceil(40 ns / clock) cycles (4 at 10 ns).
- R5: While `mem_we_n` is low, and in the cycle it returns high, `mem_addr` and `mem_dq_out` are stable and `mem_dq_oe` is 1.
- R6: `mem_oe_n` is 1 whenever `mem_dq_oe` is 1. During a write the output enable stays high, and during a read the controller never drives the bus.
- R7: After `mem_oe_n` rises at the end of a read, `mem_dq_oe` stays 0 for at least 20 ns, and in at least the first cycle after the rise.
- R8: A request with mask 2'b00 is accepted from idle and produces `done` on the next cycle with no memory strobe. For a read, `rdata` is 0.
- R9: `req_ready` is 0 from the cycle after a non-zero-mask request is accepted until the transaction finishes. Only one transaction is in flight at a time.
- R10: A write with only one mask bit set changes only that lane of the addressed word. The other lane keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| req_ready | output | 1 | Controller idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read word, valid with `done` |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Upper-lane control, active low |
| mem_lb_n | output | 1 | Lower-lane control, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The hardest situation to reach from the ports is a read that samples too early or a write that ends too soon. With an ideal memory model, neither would show up as a wrong value. The bench memory therefore returns a junk pattern until 55 ns after the read strobes and address settle, and it drives a different junk pattern on lanes whose control is high. It commits a write only when the strobe overlap ends, and only if the controller was driving.

Back-to-back read-then-write sequences force the bus handover. The bench times the gap between output enable rising and the controller's driver enable rising, and it also measures every write-enable and read strobe width in cycles.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURNAROUND
    } seq_state_e;

    // Control pins toward the memory (lane controls handled separately).
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    // Nanoseconds to clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 16,
    parameter int LANES   = 2,
    parameter int CNT_W   = 3,
    parameter int N_RD    = 5,
    parameter int N_SETUP = 1,
    parameter int N_PULSE = 4,
    parameter int N_REC   = 1,
    parameter int N_TA    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    input  logic              tmr_last,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              cap_en,
    output logic              wr_done,
    output logic              zero_done,
    output logic [LANES-1:0]  mask_q,
    output logic [LANES-1:0]  lane_n,
    output strobe_t           strobe,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    seq_state_e state, next;
    logic       accept;
    logic       lanes_on;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready && (req_mask != '0);
    assign zero_done = req_valid && req_ready && (req_mask == '0);
    assign cap_en    = (state == ST_RD_CAPTURE);
    assign wr_done   = (state == ST_WR_RECOVER) && tmr_last;

    always_comb begin
        next     = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        next    = ST_WR_SETUP;
                        tmr_val = CNT_W'(N_SETUP);
                    end else begin
                        next    = ST_RD_ACCESS;
                        tmr_val = CNT_W'(N_RD);
                    end
                end
            end
            ST_RD_ACCESS: if (tmr_last) next = ST_RD_CAPTURE;
            ST_RD_CAPTURE: begin
                next     = ST_TURNAROUND;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_TA);
            end
            ST_TURNAROUND: if (tmr_last) next = ST_IDLE;
            ST_WR_SETUP: begin
                if (tmr_last) begin
                    next     = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_PULSE);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_last) begin
                    next     = ST_WR_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_REC);
                end
            end
            ST_WR_RECOVER: if (tmr_last) next = ST_IDLE;
            default: next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else begin
            state <= next;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
        end
    end

    // Strobe decode per state.
    always_comb begin
        strobe   = STROBE_OFF;
        lanes_on = 1'b0;
        unique case (state)
            ST_RD_ACCESS, ST_RD_CAPTURE: begin
                strobe.ce_n = 1'b0;
                strobe.oe_n = 1'b0;
                lanes_on    = 1'b1;
            end
            ST_WR_SETUP, ST_WR_RECOVER: begin
                strobe.ce_n  = 1'b0;
                strobe.drive = 1'b1;
                lanes_on     = 1'b1;
            end
            ST_WR_PULSE: begin
                strobe.ce_n  = 1'b0;
                strobe.we_n  = 1'b0;
                strobe.drive = 1'b1;
                lanes_on     = 1'b1;
            end
            default: ;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_n[l] = !(lanes_on && mask_q[l]);
    end
endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              wr_done,
    input  logic              zero_done,
    input  logic [LANES-1:0]  mask_q,
    input  logic [DATA_W-1:0] dq_in,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int LANE_W = DATA_W / LANES;

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= cap_en || wr_done || zero_done;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst || zero_done) begin
                rdata[l*LANE_W +: LANE_W] <= '0;
            end else if (cap_en) begin
                rdata[l*LANE_W +: LANE_W] <= mask_q[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
            end
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 16,
    parameter int CLK_NS  = 10,
    parameter int T_RC    = 55,
    parameter int T_AA    = 55,
    parameter int T_DOE   = 30,
    parameter int T_WC    = 55,
    parameter int T_AW    = 50,
    parameter int T_PWE   = 40,
    parameter int T_PWB   = 45,
    parameter int T_SD    = 25,
    parameter int T_SA    = 0,
    parameter int T_HZOE  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int LANES   = 2;
    localparam int RD_CYC  = imax(imax(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_DOE, CLK_NS)),
                                  ns_to_cyc(T_RC, CLK_NS));
    // The capture state is the last strobed cycle, so the access state takes one less.
    localparam int N_RD    = imax(1, RD_CYC - 1);
    localparam int N_SETUP = ns_to_cyc(T_SA, CLK_NS);
    localparam int N_PULSE = imax(imax(ns_to_cyc(T_PWE, CLK_NS), ns_to_cyc(T_SD, CLK_NS)),
                                  imax(ns_to_cyc(T_AW, CLK_NS) - N_SETUP,
                                       ns_to_cyc(T_PWB, CLK_NS) - N_SETUP));
    localparam int N_REC   = imax(1, ns_to_cyc(T_WC, CLK_NS) - N_SETUP - N_PULSE);
    localparam int N_TA    = ns_to_cyc(T_HZOE, CLK_NS);
    localparam int N_MAX   = imax(imax(N_RD, N_SETUP), imax(imax(N_PULSE, N_REC), N_TA));
    localparam int CNT_W   = imax(1, $clog2(N_MAX + 1));

    logic             tmr_last, tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             cap_en, wr_done, zero_done;
    logic [LANES-1:0] mask_q, lane_n;
    strobe_t          strobe;

    sram_lane_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .CNT_W(CNT_W),
        .N_RD(N_RD), .N_SETUP(N_SETUP), .N_PULSE(N_PULSE), .N_REC(N_REC), .N_TA(N_TA)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .req_ready(req_ready),
        .tmr_last(tmr_last), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .cap_en(cap_en), .wr_done(wr_done), .zero_done(zero_done),
        .mask_q(mask_q), .lane_n(lane_n), .strobe(strobe),
        .addr_q(mem_addr), .wdata_q(mem_dq_out)
    );

    sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
    );

    sram_lane_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
        .clk(clk), .rst(rst), .cap_en(cap_en), .wr_done(wr_done), .zero_done(zero_done),
        .mask_q(mask_q), .dq_in(mem_dq_in), .done(done), .rdata(rdata)
    );

    assign mem_ce_n  = strobe.ce_n;
    assign mem_oe_n  = strobe.oe_n;
    assign mem_we_n  = strobe.we_n;
    assign mem_dq_oe = strobe.drive;
    assign mem_lb_n  = lane_n[0];
    assign mem_ub_n  = lane_n[1];
endmodule

// File: rtl/sram_lane_ctrl_checker.sv
module sram_lane_ctrl_checker #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    a_r1_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    a_r4_we_needs_select: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && !(mem_ub_n && mem_lb_n)));

    a_r5_stable_in_pulse: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

    a_r5_hold_after_pulse: assert property (@(posedge clk) disable iff (rst)
        ($past(!mem_we_n) && mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    a_r7_release_gap: assert property (@(posedge clk) disable iff (rst)
        $past(!mem_oe_n) |-> !mem_dq_oe);

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> !req_ready);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;
    localparam int PULSE_MIN_CYC = 4;   // 40 ns at 10 ns
    localparam int READ_MIN_CYC  = 6;   // 55 ns at 10 ns
    localparam int ACCESS_NS     = 55;
    localparam int FLOAT_NS      = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, done;
    logic [15:0] rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'h0000;

    always #5 clk = ~clk;

    sram_lane_ctrl u_sram_lane_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mem_model [int];
    logic [15:0] ref_mem   [int];
    logic        rd_on;
    time         rd_t0 = 0;
    time         oe_hi_t = 0;
    int          ce_falls = 0;

    assign rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;

    always @(posedge rd_on or mem_addr or mem_lb_n or mem_ub_n) rd_t0 = $time;
    always @(negedge mem_ce_n) ce_falls++;

    initial forever begin
        logic [15:0] w;
        #1;
        if (rd_on && ($time - rd_t0 >= ACCESS_NS)) begin
            w = mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 16'h0000;
        end else begin
            w = 16'hE1E1;
        end
        if (mem_lb_n) w[7:0]  = 8'hA5;
        if (mem_ub_n) w[15:8] = 8'h5A;
        mem_dq_in = w;
    end

    // R7: release gap between output enable rising and controller driving
    always @(posedge mem_oe_n) oe_hi_t = $time;
    always @(posedge mem_dq_oe) begin
        if (!rst && oe_hi_t > 0)
            chk(($time - oe_hi_t) >= FLOAT_NS, "R7", "drive after float time (ns)",
                32'($time - oe_hi_t), 32'(FLOAT_NS));
    end

    // Write commit at end of strobe overlap, plus strobe width measurements.
    logic        p_strobe = 1'b0, p_drive = 1'b0, p_lb = 1'b1, p_ub = 1'b1;
    logic [16:0] p_addr = '0;
    logic [15:0] p_data = '0;
    int          we_cyc = 0, oe_cyc = 0;

    always @(negedge clk) begin
        logic s;
        logic [15:0] old, d;
        s = !mem_ce_n && !mem_we_n && !(mem_lb_n && mem_ub_n);
        if (p_strobe && !s) begin
            old = mem_model.exists(int'(p_addr)) ? mem_model[int'(p_addr)] : 16'h0000;
            d   = p_drive ? p_data : 16'hDEAD;
            if (!p_lb) old[7:0]  = d[7:0];
            if (!p_ub) old[15:8] = d[15:8];
            mem_model[int'(p_addr)] = old;
        end
        p_strobe = s; p_drive = mem_dq_oe; p_lb = mem_lb_n; p_ub = mem_ub_n;
        p_addr = mem_addr; p_data = mem_dq_out;

        if (!rst) begin
            if (!mem_we_n) we_cyc++;
            else if (we_cyc > 0) begin
                chk(we_cyc >= PULSE_MIN_CYC, "R4", "write pulse cycles",
                    32'(we_cyc), 32'(PULSE_MIN_CYC));
                we_cyc = 0;
            end
            if (!mem_oe_n) begin
                oe_cyc++;
                chk(!mem_dq_oe, "R6", "drive while output enabled", 32'(mem_dq_oe), 32'd0);
            end else if (oe_cyc > 0) begin
                chk(oe_cyc >= READ_MIN_CYC, "R2", "read strobe cycles",
                    32'(oe_cyc), 32'(READ_MIN_CYC));
                oe_cyc = 0;
            end
            if (!mem_we_n)
                chk(mem_oe_n == 1'b1, "R6", "oe high during write", 32'(mem_oe_n), 32'd1);
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          is_read;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   done_width = 0;

    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (done) begin
                done_width++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    if (e.is_read)
                        chk(rdata === e.data, e.tag, "read data", 32'(rdata), 32'(e.data));
                    else
                        chk(1'b1, e.tag, "write done", 32'd1, 32'd1);
                end
            end else begin
                done_width = 0;
            end
            if (done_width > 1 && exp_q.size() == 0)
                chk(1'b0, "R2", "done wider than one cycle", 32'(done_width), 32'd1);
        end
    end

    function automatic logic [15:0] ref_read(input int a, input logic [1:0] m);
        logic [15:0] w;
        w = ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
        if (!m[0]) w[7:0]  = 8'h00;
        if (!m[1]) w[15:8] = 8'h00;
        return w;
    endfunction

    task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] m, input string tag);
        exp_t e;
        logic [15:0] w;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.is_read = !wr;
        e.tag     = tag;
        e.data    = ref_read(int'(a), m);
        if (wr) begin
            w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
            if (m[0]) w[7:0]  = d[7:0];
            if (m[1]) w[15:8] = d[15:8];
            ref_mem[int'(a)] = w;
        end
        if (!wr && m == 2'b00) e.data = 16'h0000;
        exp_q.push_back(e);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        if (m != 2'b00)
            chk(req_ready == 1'b0, "R9", "ready low while busy", 32'(req_ready), 32'd0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int falls0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        chk(done == 1'b0, "R1", "done after reset", 32'(done), 32'd0);
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'b11111, "R1",
            "strobes idle", 32'({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 32'h1f);
        chk(mem_dq_oe == 1'b0, "R1", "no drive idle", 32'(mem_dq_oe), 32'd0);

        issue(1'b1, 17'h00010, 16'h1234, 2'b11, "R4");
        issue(1'b0, 17'h00010, 16'h0000, 2'b11, "R2");
        issue(1'b1, 17'h00010, 16'hABCD, 2'b01, "R10");
        issue(1'b0, 17'h00010, 16'h0000, 2'b11, "R10");
        issue(1'b1, 17'h00010, 16'h9977, 2'b10, "R10");
        issue(1'b0, 17'h00010, 16'h0000, 2'b11, "R10");
        issue(1'b0, 17'h00010, 16'h0000, 2'b01, "R3");
        issue(1'b0, 17'h00010, 16'h0000, 2'b10, "R3");

        falls0 = ce_falls;
        issue(1'b1, 17'h00010, 16'hFFFF, 2'b00, "R8");
        issue(1'b0, 17'h00010, 16'h0000, 2'b00, "R8");
        chk(ce_falls == falls0, "R8", "no strobe for empty mask", 32'(ce_falls), 32'(falls0));
        issue(1'b0, 17'h00010, 16'h0000, 2'b11, "R8");

        issue(1'b1, 17'h1FFFF, 16'hC3C3, 2'b11, "R4");
        issue(1'b1, 17'h00000, 16'h0F0F, 2'b11, "R4");
        issue(1'b0, 17'h1FFFF, 16'h0000, 2'b11, "R2");
        issue(1'b1, 17'h00000, 16'h7100, 2'b10, "R7");
        issue(1'b0, 17'h00000, 16'h0000, 2'b11, "R7");

        for (int i = 0; i < 8; i++)
            issue(1'b1, 17'(i * 4099), 16'(16'h1111 * (i + 1) ^ 16'h0F30), 2'(i % 3 + 1), "R5");
        for (int i = 0; i < 8; i++)
            issue(1'b0, 17'(i * 4099), 16'h0000, 2'(3 - i % 3), "R5");

        repeat (5) @(negedge clk);
        chk(req_ready == 1'b1 && mem_ce_n == 1'b1, "R1", "idle after traffic",
            32'({req_ready, mem_ce_n}), 32'h3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #500000;
        chk(1'b0, "R9", "watchdog expired", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule